// File: doc/BRIEF.md
# Age-Ordered Vector Issue Queue with Full-Queue Slow Region

This block holds dispatched vector micro-ops until their source operands are available and then sends them to execution, always picking the oldest ready one. Each dispatched op carries a destination tag, a latency class for its own result, and up to `NSRC` source tags, each with a flag that says whether that operand is already available. A result broadcast bus tells the queue that a given tag is now produced and which latency class its producer had. Matching sources become ready.

Entries are kept in age order in a collapsing shift structure, so slot 0 always holds the oldest entry. When every slot is occupied, the `SLOW_DEPTH` oldest slots form a slow region. A source in that region that is woken by a single-cycle producer becomes ready one cycle later than normal. Producers of any other class, and any entry outside the region or in a queue with a free slot, get the normal wakeup timing. Code that keeps the queue from filling, for example by inserting bubbles, therefore sees back-to-back issue of dependent single-cycle ops.

Top module: `vq_age_issue_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1 and `iss_valid` is 0.
- R2: `disp_ready` is 0 exactly while all `DEPTH` slots are occupied. A dispatch offered while `disp_ready` is 0 is dropped and never issues.
- R3: At most one entry issues per cycle. It is the oldest entry whose sources are all ready, and `iss_dst_tag`/`iss_dst_lat` carry that entry's destination tag and class. Entries ready at the same time issue in dispatch order on consecutive cycles.
- R4: An entry outside the slow region whose last missing source matches a broadcast in cycle t is presented on the issue port in cycle t+1, whatever the broadcast class.
- R5: While the queue is full, the slow region is the `SLOW_DEPTH` oldest slots. An entry there woken by a broadcast of class one-cycle (`wake_lat` code 0) in cycle t issues no earlier than cycle t+2. A full-queue chain of dependent one-cycle ops therefore issues one op every two cycles.
- R6: A slow-region entry woken by a multi-cycle producer (code 1) or a load (code 2) gets no extra delay and issues in cycle t+1.
- R7: While at least one slot is free, no entry gets the extra delay. A dependent chain of one-cycle ops issues on consecutive cycles.
- R8: The slow-region decision is taken in the cycle the matching broadcast arrives. A delayed source stays delayed even if the queue stops being full in the next cycle.
- R9: A source whose tag matches a broadcast in the same cycle it is dispatched is captured as ready.
- R10: An entry issues only when all of its sources are ready. One matching broadcast out of two does not release it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | A micro-op is offered for dispatch |
| disp_ready | output | 1 | Queue has a free slot; the offer is taken at the edge |
| disp_dst_tag | input | TAG_W | Destination tag of the offered op |
| disp_dst_lat | input | 2 | Latency class of the offered op's result: 0 one-cycle, 1 multi-cycle, 2 load |
| disp_src_tag | input | NSRC*TAG_W | Source tags; source s in bits [s*TAG_W +: TAG_W] |
| disp_src_rdy | input | NSRC | Per-source flag: operand already available |
| wake_valid | input | 1 | A result broadcast is present |
| wake_tag | input | TAG_W | Tag being produced |
| wake_lat | input | 2 | Latency class of the producer, same encoding as disp_dst_lat |
| iss_valid | output | 1 | An entry is issued this cycle |
| iss_dst_tag | output | TAG_W | Destination tag of the issued entry |
| iss_dst_lat | output | 2 | Latency class of the issued entry |

## Verification
On every cycle, the assertions check four things. A delayed wakeup only happens while the queue is full and only for a one-cycle producer class. Each delayed source resolves in exactly the next cycle. An accepted dispatch without an issue grows the occupancy by one, and the select grant stays one-hot and matches the reported index. The actual issue timing can only be shown by the bench's scenarios: a full queue compared with one that has a free slot, a consumer inside compared with one just outside the slow region, each producer class, and full-queue and bubbled dependent chains. The same scenarios cover same-cycle dispatch bypass, two-source release and age order among simultaneously ready entries.

// File: rtl/vq_iq_pkg.sv
`timescale 1ns/1ps
package vq_iq_pkg;

  // Producer latency classes carried on dispatch and on the broadcast bus.
  typedef enum logic [1:0] {
    LAT_ONE   = 2'd0,
    LAT_MULTI = 2'd1,
    LAT_LOAD  = 2'd2
  } lat_e;

  // A slot belongs to the slow region only while the queue is full and the
  // slot is one of the oldest (low indices, since slot 0 is the oldest).
  function automatic logic in_slow_region(int unsigned idx,
                                          int unsigned slow_depth,
                                          logic q_full);
    return q_full && (idx < slow_depth);
  endfunction

  // The extra wakeup cycle applies to slow-region consumers of one-cycle
  // producers only (R5, R6).
  function automatic logic wake_delayed(logic slow, lat_e lat);
    return slow && (lat == LAT_ONE);
  endfunction

endpackage

// File: rtl/vq_src_track.sv
`timescale 1ns/1ps
// Next-state of one source operand: ready flag plus a one-cycle pending flag
// that models the slow-region wakeup delay.
module vq_src_track #(
  parameter int TAG_W = 6
) (
  input  logic              cur_rdy,
  input  logic              cur_pend,
  input  logic [TAG_W-1:0]  src_tag,
  input  logic              wake_valid,
  input  logic [TAG_W-1:0]  wake_tag,
  input  vq_iq_pkg::lat_e   wake_lat,
  input  logic              in_slow,
  output logic              nxt_rdy,
  output logic              nxt_pend,
  output logic              delay_take
);
  import vq_iq_pkg::*;

  logic tag_hit;

  always_comb begin
    tag_hit    = wake_valid && !cur_rdy && !cur_pend && (src_tag == wake_tag);
    nxt_rdy    = cur_rdy;
    nxt_pend   = cur_pend;
    delay_take = 1'b0;
    if (cur_pend) begin
      // R8: a delay taken earlier resolves now, whatever the queue state.
      nxt_rdy  = 1'b1;
      nxt_pend = 1'b0;
    end else if (tag_hit) begin
      if (wake_delayed(in_slow, wake_lat)) begin
        nxt_pend   = 1'b1;
        delay_take = 1'b1;
      end else begin
        nxt_rdy = 1'b1;
      end
    end
  end

endmodule

// File: rtl/vq_oldest_pick.sv
`timescale 1ns/1ps
// Lowest-index (oldest) request wins.
module vq_oldest_pick #(
  parameter int N = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  logic [N-1:0] gnt;

  // Prefix form of the grant, kept separate from the index search below.
  assign gnt[0] = req[0];
  for (genvar i = 1; i < N; i++) begin : g_gnt
    assign gnt[i] = req[i] && !(|req[i-1:0]);
  end

  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

  assert_grant_onehot_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  assert_grant_index_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    any |-> gnt[idx]);

  assert_grant_any_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    any == (|gnt));

endmodule

// File: rtl/vq_age_issue_queue.sv
`timescale 1ns/1ps
module vq_age_issue_queue #(
  parameter int DEPTH      = 16,
  parameter int SLOW_DEPTH = 4,
  parameter int TAG_W      = 6,
  parameter int NSRC       = 2,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  disp_valid,
  output logic                  disp_ready,
  input  logic [TAG_W-1:0]      disp_dst_tag,
  input  logic [1:0]            disp_dst_lat,
  input  logic [NSRC*TAG_W-1:0] disp_src_tag,
  input  logic [NSRC-1:0]       disp_src_rdy,
  input  logic                  wake_valid,
  input  logic [TAG_W-1:0]      wake_tag,
  input  logic [1:0]            wake_lat,
  output logic                  iss_valid,
  output logic [TAG_W-1:0]      iss_dst_tag,
  output logic [1:0]            iss_dst_lat
);
  import vq_iq_pkg::*;

  // ---------------- storage (slot 0 = oldest) ----------------
  logic [CNT_W-1:0] count;
  logic [TAG_W-1:0] e_dst   [DEPTH];
  logic [1:0]       e_lat   [DEPTH];
  logic [TAG_W-1:0] e_stag  [DEPTH][NSRC];
  logic             e_srdy  [DEPTH][NSRC];
  logic             e_spend [DEPTH][NSRC];

  // ---------------- named internal events ----------------
  lat_e             wake_cls;
  logic             q_full;
  logic             disp_fire;
  logic             iss_fire;
  logic [IDX_W-1:0] sel_idx;
  logic [CNT_W-1:0] wpos;
  logic [DEPTH-1:0] slot_valid;
  logic [DEPTH-1:0] slot_slow;
  logic [DEPTH-1:0] slot_req;
  logic             delay_evt;
  logic             pend_any;

  logic             n_srdy  [DEPTH][NSRC];
  logic             n_spend [DEPTH][NSRC];
  logic             n_delay [DEPTH][NSRC];

  logic             new_rdy   [NSRC];
  logic             new_pend  [NSRC];
  logic             new_delay [NSRC];

  assign wake_cls   = lat_e'(wake_lat);
  assign q_full     = (count == CNT_W'(DEPTH));
  assign disp_ready = !q_full;                       // R2
  assign disp_fire  = disp_valid && disp_ready;
  assign iss_fire   = iss_valid;
  assign wpos       = count - CNT_W'(iss_fire);

  // ---------------- per-slot operand tracking ----------------
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    assign slot_valid[i] = CNT_W'(i) < count;
    // R5/R7: slow membership evaluated at the slot's current index.
    assign slot_slow[i]  = slot_valid[i] && in_slow_region(i, SLOW_DEPTH, q_full);

    for (genvar s = 0; s < NSRC; s++) begin : g_src
      vq_src_track #(.TAG_W(TAG_W)) u_trk (
        .cur_rdy    (e_srdy[i][s]),
        .cur_pend   (e_spend[i][s]),
        .src_tag    (e_stag[i][s]),
        .wake_valid (wake_valid),
        .wake_tag   (wake_tag),
        .wake_lat   (wake_cls),
        .in_slow    (slot_slow[i]),
        .nxt_rdy    (n_srdy[i][s]),
        .nxt_pend   (n_spend[i][s]),
        .delay_take (n_delay[i][s])
      );
    end
  end

  // R9: the incoming op sees the same broadcast; a free slot exists, so it is
  // never in the slow region.
  for (genvar s = 0; s < NSRC; s++) begin : g_new
    vq_src_track #(.TAG_W(TAG_W)) u_trk_new (
      .cur_rdy    (disp_src_rdy[s]),
      .cur_pend   (1'b0),
      .src_tag    (disp_src_tag[s*TAG_W +: TAG_W]),
      .wake_valid (wake_valid),
      .wake_tag   (wake_tag),
      .wake_lat   (wake_cls),
      .in_slow    (1'b0),
      .nxt_rdy    (new_rdy[s]),
      .nxt_pend   (new_pend[s]),
      .delay_take (new_delay[s])
    );
  end

  // R10: ready only with every source ready.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_req[i] = slot_valid[i];
      for (int s = 0; s < NSRC; s++) begin
        slot_req[i] = slot_req[i] && e_srdy[i][s];
      end
    end
  end

  always_comb begin
    delay_evt = 1'b0;
    pend_any  = 1'b0;
    for (int s = 0; s < NSRC; s++) begin
      delay_evt = delay_evt || new_delay[s];
    end
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < NSRC; s++) begin
        delay_evt = delay_evt || n_delay[i][s];
        pend_any  = pend_any  || (slot_valid[i] && e_spend[i][s]);
      end
    end
  end

  // ---------------- select (R3) ----------------
  vq_oldest_pick #(.N(DEPTH)) u_pick (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (slot_req),
    .any   (iss_valid),
    .idx   (sel_idx)
  );

  assign iss_dst_tag = e_dst[sel_idx];
  assign iss_dst_lat = e_lat[sel_idx];

  // ---------------- collapse + append ----------------
  logic [TAG_W-1:0] d_dst   [DEPTH];
  logic [1:0]       d_lat   [DEPTH];
  logic [TAG_W-1:0] d_stag  [DEPTH][NSRC];
  logic             d_srdy  [DEPTH][NSRC];
  logic             d_spend [DEPTH][NSRC];

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      int unsigned up;
      up = (i < DEPTH - 1) ? i + 1 : i;
      if (iss_fire && (IDX_W'(i) >= sel_idx)) begin
        d_dst[i] = e_dst[up];
        d_lat[i] = e_lat[up];
        for (int s = 0; s < NSRC; s++) begin
          d_stag[i][s]  = e_stag[up][s];
          d_srdy[i][s]  = n_srdy[up][s];
          d_spend[i][s] = n_spend[up][s];
        end
      end else begin
        d_dst[i] = e_dst[i];
        d_lat[i] = e_lat[i];
        for (int s = 0; s < NSRC; s++) begin
          d_stag[i][s]  = e_stag[i][s];
          d_srdy[i][s]  = n_srdy[i][s];
          d_spend[i][s] = n_spend[i][s];
        end
      end
      if (disp_fire && (CNT_W'(i) == wpos)) begin
        d_dst[i] = disp_dst_tag;
        d_lat[i] = disp_dst_lat;
        for (int s = 0; s < NSRC; s++) begin
          d_stag[i][s]  = disp_src_tag[s*TAG_W +: TAG_W];
          d_srdy[i][s]  = new_rdy[s];
          d_spend[i][s] = new_pend[s];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;                                   // R1
      for (int i = 0; i < DEPTH; i++) begin
        e_dst[i] <= '0;
        e_lat[i] <= '0;
        for (int s = 0; s < NSRC; s++) begin
          e_stag[i][s]  <= '0;
          e_srdy[i][s]  <= 1'b0;
          e_spend[i][s] <= 1'b0;
        end
      end
    end else begin
      count <= count + CNT_W'(disp_fire) - CNT_W'(iss_fire);
      for (int i = 0; i < DEPTH; i++) begin
        e_dst[i] <= d_dst[i];
        e_lat[i] <= d_lat[i];
        for (int s = 0; s < NSRC; s++) begin
          e_stag[i][s]  <= d_stag[i][s];
          e_srdy[i][s]  <= d_srdy[i][s];
          e_spend[i][s] <= d_spend[i][s];
        end
      end
    end
  end

  // ---------------- assertions ----------------
  assert_no_overflow_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  assert_accept_grows_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (disp_fire && !iss_fire) |=> count == $past(count) + CNT_W'(1));

  assert_delay_only_full_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    delay_evt |-> q_full);

  assert_delay_class_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    delay_evt |-> (wake_cls == LAT_ONE));

  assert_pend_follows_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    delay_evt |=> pend_any);

  assert_pend_once_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    pend_any |-> $past(delay_evt));

endmodule

// File: tb/vq_age_issue_queue_bench.sv
`timescale 1ns/1ps
module vq_age_issue_queue_bench;
  localparam int DEPTH = 16;
  localparam int SLOW  = 4;
  localparam int TAG_W = 6;
  localparam int NSRC  = 2;
  localparam logic [1:0] C_ONE = 2'd0, C_MULTI = 2'd1, C_LOAD = 2'd2;
  localparam logic [TAG_W-1:0] NEVER = 6'd63;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic disp_valid = 1'b0;
  logic disp_ready;
  logic [TAG_W-1:0] disp_dst_tag = '0;
  logic [1:0] disp_dst_lat = '0;
  logic [NSRC*TAG_W-1:0] disp_src_tag = '0;
  logic [NSRC-1:0] disp_src_rdy = '0;
  logic wake_valid = 1'b0;
  logic [TAG_W-1:0] wake_tag = '0;
  logic [1:0] wake_lat = '0;
  logic iss_valid;
  logic [TAG_W-1:0] iss_dst_tag;
  logic [1:0] iss_dst_lat;

  vq_age_issue_queue #(.DEPTH(DEPTH), .SLOW_DEPTH(SLOW), .TAG_W(TAG_W), .NSRC(NSRC)) u_vq_age_issue_queue (
    .clk(clk), .rst_n(rst_n),
    .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_dst_tag(disp_dst_tag), .disp_dst_lat(disp_dst_lat),
    .disp_src_tag(disp_src_tag), .disp_src_rdy(disp_src_rdy),
    .wake_valid(wake_valid), .wake_tag(wake_tag), .wake_lat(wake_lat),
    .iss_valid(iss_valid), .iss_dst_tag(iss_dst_tag), .iss_dst_lat(iss_dst_lat)
  );

  always #10 clk = ~clk;   // 50 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  int iss_cyc [64];

  task automatic check_eq(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    disp_valid = 1'b0;
    wake_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 64; k++) iss_cyc[k] = -1;
    @(negedge clk);
  endtask

  // Called at a negedge; the op is offered at the following rising edge.
  task automatic push(input logic [TAG_W-1:0] dst, input logic [1:0] lat,
                      input logic [TAG_W-1:0] t0, input logic r0,
                      input logic [TAG_W-1:0] t1, input logic r1);
    disp_valid   = 1'b1;
    disp_dst_tag = dst;
    disp_dst_lat = lat;
    disp_src_tag = {t1, t0};
    disp_src_rdy = {r1, r0};
    @(negedge clk);
    disp_valid = 1'b0;
  endtask

  task automatic push_fillers(int n);
    for (int k = 0; k < n; k++) push(6'd62, C_MULTI, NEVER, 1'b0, NEVER, 1'b0);
  endtask

  task automatic ext_wake(input logic [TAG_W-1:0] tag, input logic [1:0] lat);
    wake_valid = 1'b1;
    wake_tag   = tag;
    wake_lat   = lat;
  endtask

  // Acts as the execution side: every issued op is broadcast in the cycle it
  // issues, with its own class. Optionally keeps the queue topped up.
  task automatic run(int n, bit fill);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (iss_valid) begin
        if (iss_cyc[iss_dst_tag] < 0) iss_cyc[iss_dst_tag] = cyc;
        wake_valid = 1'b1;
        wake_tag   = iss_dst_tag;
        wake_lat   = iss_dst_lat;
      end else begin
        wake_valid = 1'b0;
      end
      if (fill && disp_ready) begin
        disp_valid   = 1'b1;
        disp_dst_tag = 6'd62;
        disp_dst_lat = C_MULTI;
        disp_src_tag = {NEVER, NEVER};
        disp_src_rdy = 2'b00;
      end else begin
        disp_valid = 1'b0;
      end
    end
    wake_valid = 1'b0;
    disp_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check_eq("R1 disp_ready after reset", int'(disp_ready), 1);
    check_eq("R1 iss_valid after reset", int'(iss_valid), 0);
  endtask

  task automatic t_full_one_cycle();
    int t;
    do_reset();
    push(6'd1, C_ONE, 6'd40, 1'b0, NEVER, 1'b1);
    push_fillers(15);
    check_eq("R2 disp_ready when full", int'(disp_ready), 0);
    push(6'd11, C_MULTI, NEVER, 1'b1, NEVER, 1'b1);   // offered while full
    ext_wake(6'd40, C_ONE);
    t = cyc;
    run(8, 1'b0);
    check_eq("R5 slow consumer of one-cycle producer", iss_cyc[1], t + 2);
    check_eq("R2 dropped dispatch never issues", iss_cyc[11], -1);
  endtask

  task automatic t_full_long_classes();
    logic [1:0] cls [2] = '{C_MULTI, C_LOAD};
    for (int c = 0; c < 2; c++) begin
      int t;
      do_reset();
      push(6'd1, C_ONE, 6'd40, 1'b0, NEVER, 1'b1);
      push_fillers(15);
      ext_wake(6'd40, cls[c]);
      t = cyc;
      run(5, 1'b0);
      check_eq(c == 0 ? "R6 slow consumer of multi-cycle producer"
                      : "R6 slow consumer of load", iss_cyc[1], t + 1);
    end
  endtask

  task automatic t_fast_slot_when_full();
    int t;
    do_reset();
    push_fillers(SLOW + 1);
    push(6'd2, C_ONE, 6'd41, 1'b0, NEVER, 1'b1);      // slot SLOW+1
    push_fillers(DEPTH - SLOW - 2);
    check_eq("R4 queue full before wake", int'(disp_ready), 0);
    ext_wake(6'd41, C_ONE);
    t = cyc;
    run(5, 1'b0);
    check_eq("R4 fast-region consumer of one-cycle producer", iss_cyc[2], t + 1);
  endtask

  task automatic t_one_free_slot();
    int t;
    do_reset();
    push(6'd1, C_ONE, 6'd40, 1'b0, NEVER, 1'b1);
    push_fillers(DEPTH - 2);
    check_eq("R7 one slot still free", int'(disp_ready), 1);
    ext_wake(6'd40, C_ONE);
    t = cyc;
    run(5, 1'b0);
    check_eq("R7 oldest slot, queue not full, no delay", iss_cyc[1], t + 1);
  endtask

  task automatic t_chain_full();
    int t;
    do_reset();
    for (int k = 0; k < DEPTH; k++)
      push(TAG_W'(k + 1), C_ONE, (k == 0) ? 6'd40 : TAG_W'(k), 1'b0, NEVER, 1'b1);
    ext_wake(6'd40, C_MULTI);
    t = cyc;
    run(60, 1'b1);
    check_eq("R6 chain head after multi-cycle wake", iss_cyc[1], t + 1);
    for (int k = 2; k <= DEPTH; k++)
      check_eq("R5 R8 full-queue chain gap", iss_cyc[k] - iss_cyc[k-1], 2);
  endtask

  task automatic t_chain_bubbled();
    int t;
    do_reset();
    for (int k = 0; k < 8; k++)
      push(TAG_W'(k + 1), C_ONE, (k == 0) ? 6'd40 : TAG_W'(k), 1'b0, NEVER, 1'b1);
    ext_wake(6'd40, C_ONE);
    t = cyc;
    run(20, 1'b0);
    check_eq("R7 bubbled chain head", iss_cyc[1], t + 1);
    for (int k = 2; k <= 8; k++)
      check_eq("R7 bubbled chain gap", iss_cyc[k] - iss_cyc[k-1], 1);
  endtask

  task automatic t_age_order();
    int t;
    do_reset();
    push(6'd7, C_MULTI, 6'd44, 1'b0, NEVER, 1'b1);
    push(6'd8, C_MULTI, 6'd44, 1'b0, NEVER, 1'b1);
    push(6'd9, C_MULTI, 6'd44, 1'b0, NEVER, 1'b1);
    ext_wake(6'd44, C_MULTI);
    t = cyc;
    run(6, 1'b0);
    check_eq("R3 oldest first", iss_cyc[7], t + 1);
    check_eq("R3 second oldest", iss_cyc[8], t + 2);
    check_eq("R3 youngest last", iss_cyc[9], t + 3);
  endtask

  task automatic t_two_sources();
    int t;
    do_reset();
    push(6'd5, C_LOAD, 6'd42, 1'b0, 6'd43, 1'b0);
    ext_wake(6'd42, C_MULTI);
    run(3, 1'b0);
    check_eq("R10 one of two sources ready", iss_cyc[5], -1);
    ext_wake(6'd43, C_ONE);
    t = cyc;
    run(3, 1'b0);
    check_eq("R10 both sources ready", iss_cyc[5], t + 1);
  endtask

  task automatic t_dispatch_bypass();
    int t;
    do_reset();
    disp_valid   = 1'b1;
    disp_dst_tag = 6'd10;
    disp_dst_lat = C_MULTI;
    disp_src_tag = {NEVER, 6'd45};
    disp_src_rdy = 2'b10;
    ext_wake(6'd45, C_MULTI);
    t = cyc;
    run(4, 1'b0);
    check_eq("R9 same-cycle wake captured at dispatch", iss_cyc[10], t + 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    t_reset();
    t_full_one_cycle();
    t_full_long_classes();
    t_fast_slot_when_full();
    t_one_free_slot();
    t_chain_full();
    t_chain_bubbled();
    t_age_order();
    t_two_sources();
    t_dispatch_bypass();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

endmodule